// File: doc/BRIEF.md
# Serial Bus Acknowledge and Status Controller

This block sits beside the shift register of a clocked serial bus port that moves 8-bit transfers, with the acknowledge carried on the ninth serial clock. It watches the serial clock and a transfer-start strobe to find the acknowledge slot. It pulls the data line low for the acknowledge when software asks for one. It also keeps three read-only status flags: bus release seen, command seen and acknowledge seen.

Software can ask for an acknowledge in two ways. The first is an auto-acknowledge enable, a read/write bit. The second is a one-shot trigger bit, which is write-only and clears itself once its acknowledge has gone out. The serial clock arrives as a level that is already synchronous to the system clock. Release and command events arrive as single-cycle pulses from detectors outside the block. The address comparator outside the block reports when an address byte has been received and whether it matched.

Top module: `sbus_ack_ctrl`

## Requirements
- R1: After synchronous reset, `sda_o` is 1 (line released), and `ack_en_o`, `rel_flag_o`, `cmd_flag_o` and `ack_flag_o` are all 0.
- R2: With the auto enable at 1 before the 8th SCK rise of a transfer, `sda_o` is 0 from the low phase that follows the 8th rise until the falling edge after the 9th rise. During the eight data cycles `sda_o` stays 1.
- R3: When the auto enable is written to 1 after the 8th rise and before the acknowledge slot, `sda_o` is 0 for the next complete SCK low-high cycle, and only one acknowledge is produced for that transfer.
- R4: While the auto enable is 0 and no trigger is pending, `sda_o` stays 1 through the ninth SCK cycle.
- R5: Writing 1 to the trigger bit when no transfer is in progress drives `sda_o` to 0 for the next complete SCK low-high cycle. The trigger then clears itself, so the SCK cycle after that leaves `sda_o` at 1.
- R6: Writing 0 to the trigger bit does not cancel a pending trigger. A trigger write made after a start strobe and before the 8th SCK rise is ignored, so no acknowledge results from it.
- R7: `ack_flag_o` sets one cycle after an SCK rise in the acknowledge slot (the 9th rise) at which `sda_i` is 0. It clears one cycle after a transfer-start strobe or on reset. A set wins over a clear in the same cycle.
- R8: `rel_flag_o` sets one cycle after a `rel_det_i` pulse. It clears one cycle after a start strobe, after `if_en_i` is 0, or after `addr_byte_i` is 1 with `addr_match_i` 0. A set wins over a clear in the same cycle.
- R9: `cmd_flag_o` sets one cycle after a `cmd_det_i` pulse. It clears one cycle after a start strobe, a `rel_det_i` pulse, or `if_en_i` at 0. A `rel_det_i` in the same cycle as `cmd_det_i` leaves the flag at 0.
- R10: `ack_en_o` shows the value last written through `ctrl_auto_i`, one cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | Serial clock level, synchronous to clk |
| sda_i | input | 1 | Serial data line level as seen on the bus |
| sda_o | output | 1 | Data line drive: 0 pulls the line low, 1 releases it |
| xfer_start_i | input | 1 | Transfer-start strobe, one cycle |
| if_en_i | input | 1 | Serial interface enable |
| addr_byte_i | input | 1 | Pulse when an address byte has been received |
| addr_match_i | input | 1 | Address compare result, valid with addr_byte_i |
| rel_det_i | input | 1 | Bus release event pulse |
| cmd_det_i | input | 1 | Command event pulse |
| ctrl_wr_i | input | 1 | Control write strobe |
| ctrl_auto_i | input | 1 | Written value of the auto-acknowledge enable |
| ctrl_trig_i | input | 1 | Written value of the one-shot trigger (only 1 acts) |
| ack_en_o | output | 1 | Current auto-acknowledge enable |
| rel_flag_o | output | 1 | Bus release detected flag |
| cmd_flag_o | output | 1 | Command detected flag |
| ack_flag_o | output | 1 | Acknowledge detected flag |

## Verification
Every flag and the enable readback is a single register, so each is due on the first clock edge after its cause. The flag checks therefore compare against a bench model one cycle after each randomly drawn event set. The data line drive reacts one clock after the SCK edge that starts or ends it. The bench holds each SCK phase for four clocks and samples two clocks into the phase, which leaves room for that one-cycle delay. The acknowledge flag is read in the middle of the ninth high phase, one cycle or more after its sampling rise. It is then read again on the clock after the next start strobe.

// File: rtl/sbus_ack_pkg.sv
package sbus_ack_pkg;

  // One cycle's worth of bus events feeding the status flags
  typedef struct packed {
    logic rel;
    logic cmd;
    logic start;
    logic if_en;
    logic addr_byte;
    logic addr_match;
  } bus_evt_t;

endpackage

// File: rtl/sbus_bit_tracker.sv
module sbus_bit_tracker #(
  parameter int BITS_PER_XFER = 8,
  parameter int CNT_W         = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic xfer_start_i,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic done_o,
  output logic busy_o,
  output logic slot_rise_o
);

  localparam logic [CNT_W-1:0] SLOT = CNT_W'(BITS_PER_XFER);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS_PER_XFER + 1);

  logic             sck_q;
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;

  assign sck_rise_o  = sck_i & ~sck_q;
  assign sck_fall_o  = ~sck_i & sck_q;
  assign done_o      = active_q & (cnt_q >= SLOT);
  assign busy_o      = active_q & (cnt_q < SLOT);
  assign slot_rise_o = sck_rise_o & active_q & (cnt_q == SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q    <= 1'b0;
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      sck_q <= sck_i;
      if (xfer_start_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
      end else if (sck_rise_o && active_q && cnt_q != LAST) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R2: the rise counter never passes one beyond the acknowledge slot
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST);

  // R2: a start strobe always returns the count to zero
  a_r2_start_zero: assert property (@(posedge clk) disable iff (rst)
    xfer_start_i |=> (cnt_q == '0) && active_q);

endmodule

// File: rtl/sbus_ack_drive.sv
module sbus_ack_drive (
  input  logic clk,
  input  logic rst,
  input  logic sck_low_i,
  input  logic sck_rise_i,
  input  logic sck_fall_i,
  input  logic done_i,
  input  logic busy_i,
  input  logic xfer_start_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_auto_i,
  input  logic ctrl_trig_i,
  output logic ack_en_o,
  output logic drive_o
);

  logic ack_en_q, trig_q, sent_q, drive_q, rose_q;
  logic auto_req, start_drive, end_drive, trig_set;

  assign auto_req    = ack_en_q & done_i & ~sent_q;
  assign start_drive = ~drive_q & sck_low_i & ~xfer_start_i & (trig_q | auto_req);
  assign end_drive   = drive_q & sck_fall_i & rose_q;
  assign trig_set    = ctrl_wr_i & ctrl_trig_i & ~busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_en_q <= 1'b0;
      trig_q   <= 1'b0;
      sent_q   <= 1'b0;
      drive_q  <= 1'b0;
      rose_q   <= 1'b0;
    end else begin
      if (ctrl_wr_i) ack_en_q <= ctrl_auto_i;

      if (trig_set)       trig_q <= 1'b1;
      else if (end_drive) trig_q <= 1'b0;

      if (xfer_start_i)   sent_q <= 1'b0;
      else if (end_drive) sent_q <= 1'b1;

      if (end_drive)        drive_q <= 1'b0;
      else if (start_drive) drive_q <= 1'b1;

      if (start_drive)                rose_q <= 1'b0;
      else if (drive_q && sck_rise_i) rose_q <= 1'b1;
    end
  end

  assign ack_en_o = ack_en_q;
  assign drive_o  = drive_q;

  // R5: the trigger only drops together with the end of its acknowledge
  a_r5_trig_self_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(trig_q) |-> $fell(drive_q));

  // R6: a trigger write during a transfer leaves the trigger idle
  a_r6_trig_busy_ignored: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr_i && ctrl_trig_i && busy_i && !trig_q) |=> !trig_q);

  // R4: no request source means the line stays released
  a_r4_no_source_idle: assert property (@(posedge clk) disable iff (rst)
    (!ack_en_q && !trig_q && !drive_q) |=> !drive_q);

  // R2: once driven, the line is held until an SCK falling edge
  a_r2_hold_to_fall: assert property (@(posedge clk) disable iff (rst)
    (drive_q && !sck_fall_i) |=> drive_q);

endmodule

// File: rtl/sbus_status_flags.sv
module sbus_status_flags
  import sbus_ack_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  bus_evt_t evt_i,
  input  logic     slot_rise_i,
  input  logic     sda_i,
  output logic     rel_o,
  output logic     cmd_o,
  output logic     ackd_o
);

  logic rel_q, cmd_q, ackd_q;
  logic ack_seen, rel_clr, cmd_set, cmd_clr;

  assign ack_seen = slot_rise_i & ~sda_i;
  assign rel_clr  = evt_i.start | ~evt_i.if_en | (evt_i.addr_byte & ~evt_i.addr_match);
  assign cmd_set  = evt_i.cmd & ~evt_i.rel;
  assign cmd_clr  = evt_i.start | evt_i.rel | ~evt_i.if_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      rel_q  <= 1'b0;
      cmd_q  <= 1'b0;
      ackd_q <= 1'b0;
    end else begin
      if (evt_i.rel)    rel_q <= 1'b1;
      else if (rel_clr) rel_q <= 1'b0;

      if (cmd_set)      cmd_q <= 1'b1;
      else if (cmd_clr) cmd_q <= 1'b0;

      if (ack_seen)         ackd_q <= 1'b1;
      else if (evt_i.start) ackd_q <= 1'b0;
    end
  end

  assign rel_o  = rel_q;
  assign cmd_o  = cmd_q;
  assign ackd_o = ackd_q;

  a_r8_rel_sets: assert property (@(posedge clk) disable iff (rst)
    evt_i.rel |=> rel_q);

  a_r8_rel_disable_clears: assert property (@(posedge clk) disable iff (rst)
    (!evt_i.if_en && !evt_i.rel) |=> !rel_q);

  a_r9_rel_beats_cmd: assert property (@(posedge clk) disable iff (rst)
    evt_i.rel |=> !cmd_q);

  a_r7_ack_sets: assert property (@(posedge clk) disable iff (rst)
    ack_seen |=> ackd_q);

  a_r7_start_clears: assert property (@(posedge clk) disable iff (rst)
    (evt_i.start && !slot_rise_i) |=> !ackd_q);

endmodule

// File: rtl/sbus_ack_ctrl.sv
module sbus_ack_ctrl
  import sbus_ack_pkg::*;
#(
  parameter int BITS_PER_XFER = 8,
  parameter int CNT_W         = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic sda_i,
  output logic sda_o,
  input  logic xfer_start_i,
  input  logic if_en_i,
  input  logic addr_byte_i,
  input  logic addr_match_i,
  input  logic rel_det_i,
  input  logic cmd_det_i,
  input  logic ctrl_wr_i,
  input  logic ctrl_auto_i,
  input  logic ctrl_trig_i,
  output logic ack_en_o,
  output logic rel_flag_o,
  output logic cmd_flag_o,
  output logic ack_flag_o
);

  logic     sck_rise, sck_fall, done, busy, slot_rise, drive;
  bus_evt_t evt;

  assign evt = '{rel: rel_det_i, cmd: cmd_det_i, start: xfer_start_i,
                 if_en: if_en_i, addr_byte: addr_byte_i, addr_match: addr_match_i};

  sbus_bit_tracker #(
    .BITS_PER_XFER(BITS_PER_XFER),
    .CNT_W        (CNT_W)
  ) u_tracker (
    .clk         (clk),
    .rst         (rst),
    .sck_i       (sck_i),
    .xfer_start_i(xfer_start_i),
    .sck_rise_o  (sck_rise),
    .sck_fall_o  (sck_fall),
    .done_o      (done),
    .busy_o      (busy),
    .slot_rise_o (slot_rise)
  );

  sbus_ack_drive u_drive (
    .clk         (clk),
    .rst         (rst),
    .sck_low_i   (~sck_i),
    .sck_rise_i  (sck_rise),
    .sck_fall_i  (sck_fall),
    .done_i      (done),
    .busy_i      (busy),
    .xfer_start_i(xfer_start_i),
    .ctrl_wr_i   (ctrl_wr_i),
    .ctrl_auto_i (ctrl_auto_i),
    .ctrl_trig_i (ctrl_trig_i),
    .ack_en_o    (ack_en_o),
    .drive_o     (drive)
  );

  sbus_status_flags u_flags (
    .clk        (clk),
    .rst        (rst),
    .evt_i      (evt),
    .slot_rise_i(slot_rise),
    .sda_i      (sda_i),
    .rel_o      (rel_flag_o),
    .cmd_o      (cmd_flag_o),
    .ackd_o     (ack_flag_o)
  );

  assign sda_o = ~drive;

  // R1: reset leaves the line released on the next cycle
  a_r1_reset_release: assert property (@(posedge clk)
    rst |=> sda_o);

  // R10: enable readback follows a write one cycle later
  a_r10_enable_readback: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_i |=> (ack_en_o == $past(ctrl_auto_i)));

endmodule

// File: tb/sbus_ack_ctrl_bench.sv
module sbus_ack_ctrl_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, sck, slave_sda, sda_line, sda_o;
  logic xfer_start, if_en, addr_byte, addr_match, rel_det, cmd_det;
  logic ctrl_wr, ctrl_auto, ctrl_trig;
  logic ack_en_o, rel_flag_o, cmd_flag_o, ack_flag_o;
  int   tests = 0;
  int   fails = 0;
  bit   finished = 1'b0;

  assign sda_line = sda_o & slave_sda;

  sbus_ack_ctrl u_sbus_ack_ctrl (
    .clk(clk), .rst(rst), .sck_i(sck), .sda_i(sda_line), .sda_o(sda_o),
    .xfer_start_i(xfer_start), .if_en_i(if_en), .addr_byte_i(addr_byte),
    .addr_match_i(addr_match), .rel_det_i(rel_det), .cmd_det_i(cmd_det),
    .ctrl_wr_i(ctrl_wr), .ctrl_auto_i(ctrl_auto), .ctrl_trig_i(ctrl_trig),
    .ack_en_o(ack_en_o), .rel_flag_o(rel_flag_o), .cmd_flag_o(cmd_flag_o),
    .ack_flag_o(ack_flag_o)
  );

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit auto_v, bit trig_v);
    ctrl_wr = 1'b1; ctrl_auto = auto_v; ctrl_trig = trig_v;
    @(negedge clk);
    ctrl_wr = 1'b0; ctrl_trig = 1'b0;
  endtask

  // Expected line level for SCK cycle cyc when an acknowledge is due
  function automatic logic exp_sda(bit due, int cyc);
    return !(due && cyc == 9);
  endfunction

  function automatic logic nxt_rel(logic cur, logic r, logic st, logic en, logic ab, logic am);
    return r | (cur & ~(st | ~en | (ab & ~am)));
  endfunction

  function automatic logic nxt_cmd(logic cur, logic c, logic r, logic st, logic en);
    return (c & ~r) | (cur & ~(st | r | ~en));
  endfunction

  task automatic sck_phase(bit lvl, logic exp, string req);
    sck = lvl;
    idle(2);
    check(req, sda_o, exp);
    idle(2);
  endtask

  // mode 0 auto before end, 1 none, 2 auto after end, 3 trigger, 4 trigger during transfer
  task automatic xfer(int mode);
    bit    due = (mode == 0) || (mode == 2) || (mode == 3);
    string req;
    case (mode)
      0: req = "R2 auto before end";
      1: req = "R4 no auto";
      2: req = "R3 auto after end";
      3: req = "R5 trigger";
      default: req = "R6 trigger in transfer";
    endcase
    wr(mode == 0, 1'b0);
    check("R10 enable readback", ack_en_o, mode == 0);
    xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    check("R7 start clears ack flag", ack_flag_o, 1'b0);
    for (int cyc = 1; cyc <= 8; cyc++) begin
      sck_phase(1'b0, exp_sda(due, cyc), req);
      if (mode == 4 && cyc == 3) wr(1'b0, 1'b1);
      sck_phase(1'b1, exp_sda(due, cyc), req);
    end
    if (mode == 2) begin
      wr(1'b1, 1'b0);
      check("R10 enable readback", ack_en_o, 1'b1);
      idle(1);
      check("R3 waits for low phase", sda_o, 1'b1);
    end
    if (mode == 3) begin
      wr(1'b0, 1'b1);
      wr(1'b0, 1'b0);
      idle(1);
      check("R6 zero write keeps trigger", sda_o, 1'b1);
    end
    if (mode == 4) slave_sda = 1'b0;
    sck_phase(1'b0, exp_sda(due, 9), req);
    sck = 1'b1;
    idle(2);
    check(req, sda_o, exp_sda(due, 9));
    check("R7 ack flag after slot", ack_flag_o, due || mode == 4);
    idle(2);
    slave_sda = 1'b1;
    for (int cyc = 10; cyc <= 11; cyc++) begin
      sck_phase(1'b0, 1'b1, req);
      sck_phase(1'b1, 1'b1, req);
    end
  endtask

  initial begin
    logic er, ec, ea;
    rst = 1'b1; sck = 1'b0; slave_sda = 1'b1; xfer_start = 1'b0; if_en = 1'b1;
    addr_byte = 1'b0; addr_match = 1'b0; rel_det = 1'b0; cmd_det = 1'b0;
    ctrl_wr = 1'b0; ctrl_auto = 1'b0; ctrl_trig = 1'b0;
    idle(4);
    rst = 1'b0;
    idle(1);
    check("R1 line", sda_o, 1'b1);
    check("R1 enable", ack_en_o, 1'b0);
    check("R1 rel", rel_flag_o, 1'b0);
    check("R1 cmd", cmd_flag_o, 1'b0);
    check("R1 ack", ack_flag_o, 1'b0);

    // Directed flag corners
    cmd_det = 1'b1; @(negedge clk); cmd_det = 1'b0;
    check("R9 cmd set", cmd_flag_o, 1'b1);
    cmd_det = 1'b1; rel_det = 1'b1; @(negedge clk); cmd_det = 1'b0; rel_det = 1'b0;
    check("R9 rel priority", cmd_flag_o, 1'b0);
    check("R8 rel set", rel_flag_o, 1'b1);
    addr_byte = 1'b1; addr_match = 1'b1; @(negedge clk);
    check("R8 match keeps rel", rel_flag_o, 1'b1);
    addr_match = 1'b0; @(negedge clk); addr_byte = 1'b0;
    check("R8 mismatch clears rel", rel_flag_o, 1'b0);

    // Acknowledge scenarios
    xfer(0);
    xfer(1);
    xfer(2);
    xfer(3);
    xfer(4);

    // Random flag traffic against the bench model
    void'($urandom(32'h5eed_1234));
    er = rel_flag_o; ec = cmd_flag_o; ea = ack_flag_o;
    for (int i = 0; i < 400; i++) begin
      rel_det    = ($urandom % 5) == 0;
      cmd_det    = ($urandom % 4) == 0;
      xfer_start = ($urandom % 9) == 0;
      if_en      = ($urandom % 6) != 0;
      addr_byte  = ($urandom % 5) == 0;
      addr_match = $urandom % 2;
      @(negedge clk);
      er = nxt_rel(er, rel_det, xfer_start, if_en, addr_byte, addr_match);
      ec = nxt_cmd(ec, cmd_det, rel_det, xfer_start, if_en);
      ea = ea & ~xfer_start;
      check("R8 random rel", rel_flag_o, er);
      check("R9 random cmd", cmd_flag_o, ec);
      check("R7 random ack", ack_flag_o, ea);
    end
    rel_det = 1'b0; cmd_det = 1'b0; xfer_start = 1'b0; if_en = 1'b1; addr_byte = 1'b0;

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule